// File: doc/BRIEF.md
# One-Time Fuse Array Controller

This block controls a one-time-programmable fuse store built from several identical fuse macros. A small register port lets software switch the block on, launch single-bit program operations, check for a rejected command, read the stored contents as aligned words, and read a boot word. The fuse cells are modelled as flip-flops inside the block. They are cleared only by a separate power-on reset (`por_n`), so they survive the ordinary system reset (`rst_n`).

Byte offsets in the fuse space are spread across the macros. The low offset bits select the macro and the remaining bits select the byte inside that macro. As a result, one aligned window word collects the same byte index from every macro, with macro m in byte lane m. Each program command blows at most one bit, and a bit can only be set. A short sequencer holds the start flag for a fixed number of cycles and applies the blow in the cycle it lets go.

The register port is plain and has no back-pressure. A write is taken in the cycle `wr_en` is high. A read requested with `rd_en` is answered with `rd_valid` and `rd_data` in the next cycle, and the port cannot stall it.

Register map (byte address on `reg_addr`, 8 bits with defaults):
- 0x00 control: bit 0 is the enable bit.
- 0x04 command:
  - bit 0 is the bit value.
  - bits 3:1 are the bit within the byte.
  - bits 9:4 are the byte within the macro.
  - bits 12:10 are the macro.
  - bit 31 is the start flag.
- 0x08 status: bit 0 is the rejected-command flag.
- 0x0C boot word.
- 0x80 to 0xFF fuse window: byte offset = address minus 0x80.

Top module: `fuse_ctrl`

## Requirements
- R1: After reset, reads of control, command and status registers return 0.
- R2: Programming macro m, byte n, bit b sets bit 8*m+b of the window word at offset 4*n. In general, bit b of fuse byte offset o appears at bit 8*(o mod 4)+b of the word at offset o with its two low bits cleared.
- R3: A write to the command register with bit 31 set, while enabled and idle, launches one program operation. Bits 30:0 of that write are kept and read back.
- R4: Command bit 31 reads 1 for exactly PROG_CYCLES (default 16) cycles after the launch edge, then 0. The fuse bit becomes visible once it reads 0.
- R5: A command with bit value 0 blows nothing. Fuse bits can only go from 0 to 1, never back.
- R6: A command write while command bit 31 still reads 1 is ignored: neither the command register nor the fuses change.
- R7: A command write while the enable bit is 0 is ignored.
- R8: A command whose byte field is 32 or more, or whose macro field is 4 or more, sets status bit 0, launches nothing and blows nothing. Status bit 0 stays set while the block remains enabled.
- R9: Writing 0 to the enable bit clears the command register, the start flag and status bit 0 at once. An operation in progress is aborted without blowing, and fuse contents are kept.
- R10: The boot register holds the fuse word at offset 0 as captured in the first cycle after `rst_n` is released. Later programming does not change it until the next system reset.
- R11: `rd_valid` is high exactly one cycle after `rd_en`, carrying the data. The two low address bits are ignored for window reads.
- R12: `por_n` clears every fuse bit, and `rst_n` leaves fuse bits untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| por_n | input | 1 | Asynchronous power-on reset of the fuse cells, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read request |
| reg_addr | input | 8 | Byte address of the register or window word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response strobe, one cycle after rd_en |

## Verification
The bound checker watches several properties on every cycle:
- fuse bits never fall, and at most one changes per cycle;
- the start flag lasts exactly PROG_CYCLES cycles when not aborted;
- a disabled block shows no start flag or error;
- a rejected command leaves the fuses unchanged, and the error flag stays sticky;
- the read response keeps its one-cycle timing.

Other behaviour needs the bench's scenarios:
- the offset-to-macro interleave and the lane placement;
- ignoring commands while busy or disabled, with the stored fields read back;
- aborting by disable;
- boot-word capture across a system reset;
- the split between system reset and power-on reset.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_CMD,
    SEL_STAT,
    SEL_BOOT,
    SEL_WIN
  } sel_e;

  // Map an address onto a register target: window half first, then the four registers.
  function automatic sel_e decode_sel(input logic in_window, input logic upper_zero,
                                      input logic [1:0] reg_idx);
    sel_e s;
    if (in_window) s = SEL_WIN;
    else if (!upper_zero) s = SEL_NONE;
    else begin
      case (reg_idx)
        2'd0: s = SEL_CTRL;
        2'd1: s = SEL_CMD;
        2'd2: s = SEL_STAT;
        default: s = SEL_BOOT;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/fuse_store.sv
module fuse_store #(
  parameter int NUM_MACROS  = 4,
  parameter int MACRO_BYTES = 32,
  localparam int MAC_IW  = $clog2(NUM_MACROS),
  localparam int WORD_IW = $clog2(MACRO_BYTES),
  localparam int CELLS   = MACRO_BYTES * 8,
  localparam int DATA_W  = 8 * NUM_MACROS
) (
  input  logic                          clk,
  input  logic                          por_n,
  input  logic                          blow_en,
  input  logic [MAC_IW-1:0]             blow_macro,
  input  logic [WORD_IW-1:0]            blow_byte,
  input  logic [2:0]                    blow_bit,
  input  logic [WORD_IW-1:0]            rd_idx,
  output logic [DATA_W-1:0]             rd_word,
  output logic [DATA_W-1:0]             word0,
  output logic [NUM_MACROS*CELLS-1:0]   cells_flat
);

  for (genvar m = 0; m < NUM_MACROS; m++) begin : g_macro
    logic [CELLS-1:0] cells;

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        cells <= '0;
      end else if (blow_en && (blow_macro == MAC_IW'(m))) begin
        cells[{blow_byte, blow_bit}] <= 1'b1;
      end
    end

    // Lane m of each window word comes from macro m.
    assign rd_word[m*8 +: 8]            = cells[{rd_idx, 3'b000} +: 8];
    assign word0[m*8 +: 8]              = cells[7:0];
    assign cells_flat[m*CELLS +: CELLS] = cells;
  end

endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq #(
  parameter int PROG_CYCLES = 16,
  localparam int CW = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic launch,
  output logic busy,
  output logic done
);

  logic [CW-1:0] cnt;
  logic          last;

  assign last = (cnt == CW'(PROG_CYCLES - 1));
  assign done = busy && enable && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!enable) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fuse_boot_latch.sv
module fuse_boot_latch #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] boot_word
);

  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b1;
      boot_word <= '0;
    end else if (pending) begin
      pending   <= 1'b0;
      boot_word <= word_in;
    end
  end

endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
  import fuse_pkg::*;
#(
  parameter int NUM_MACROS  = 4,
  parameter int MACRO_BYTES = 32,
  parameter int PROG_CYCLES = 16,
  localparam int FUSE_BYTES = NUM_MACROS * MACRO_BYTES,
  localparam int DATA_W     = 8 * NUM_MACROS,
  localparam int ADDR_W     = $clog2(FUSE_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int MAC_IW    = $clog2(NUM_MACROS);
  localparam int WORD_IW   = $clog2(MACRO_BYTES);
  localparam int BYTE_FW   = WORD_IW + 1;
  localparam int MAC_FW    = MAC_IW + 1;
  localparam int BIT_LO    = 1;
  localparam int BYTE_LO   = 4;
  localparam int MAC_LO    = BYTE_LO + BYTE_FW;
  localparam int START_POS = DATA_W - 1;
  localparam int NBITS     = FUSE_BYTES * 8;

  sel_e                sel;
  logic                en_q, en_d, err_q, busy, done;
  logic [DATA_W-2:0]   cmd_q;
  logic                wr_ctrl, wr_cmd, bad, launch;
  logic [BYTE_FW-1:0]  fld_byte;
  logic [MAC_FW-1:0]   fld_mac;
  logic [WORD_IW-1:0]  win_idx;
  logic [DATA_W-1:0]   win_word, word0, boot_word, rd_mux;
  logic [NBITS-1:0]    fuse_bits;
  logic                unused_addr_lo;

  assign sel = decode_sel(reg_addr[ADDR_W-1], reg_addr[ADDR_W-2:4] == '0, reg_addr[3:2]);
  assign win_idx        = reg_addr[ADDR_W-2:MAC_IW];
  assign unused_addr_lo = ^reg_addr[MAC_IW-1:0];

  // Enable decode, seen in the same cycle so a disable also stops a blow.
  assign wr_ctrl = wr_en && (sel == SEL_CTRL);
  assign en_d    = wr_ctrl ? wr_data[0] : en_q;

  // Command acceptance and range check.
  assign fld_byte = wr_data[BYTE_LO +: BYTE_FW];
  assign fld_mac  = wr_data[MAC_LO +: MAC_FW];
  assign bad      = (fld_byte >= BYTE_FW'(MACRO_BYTES)) || (fld_mac >= MAC_FW'(NUM_MACROS));
  assign wr_cmd   = wr_en && (sel == SEL_CMD) && wr_data[START_POS] && en_q && !busy;
  assign launch   = wr_cmd && !bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      err_q <= 1'b0;
      cmd_q <= '0;
    end else begin
      en_q <= en_d;
      if (!en_d) begin
        cmd_q <= '0;
        err_q <= 1'b0;
      end else if (wr_cmd) begin
        if (bad) err_q <= 1'b1;
        else     cmd_q <= wr_data[DATA_W-2:0];
      end
    end
  end

  fuse_prog_seq #(.PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (en_d),
    .launch (launch),
    .busy   (busy),
    .done   (done)
  );

  fuse_store #(.NUM_MACROS(NUM_MACROS), .MACRO_BYTES(MACRO_BYTES)) u_store (
    .clk        (clk),
    .por_n      (por_n),
    .blow_en    (done && cmd_q[0]),
    .blow_macro (cmd_q[MAC_LO +: MAC_IW]),
    .blow_byte  (cmd_q[BYTE_LO +: WORD_IW]),
    .blow_bit   (cmd_q[BIT_LO +: 3]),
    .rd_idx     (win_idx),
    .rd_word    (win_word),
    .word0      (word0),
    .cells_flat (fuse_bits)
  );

  fuse_boot_latch #(.DATA_W(DATA_W)) u_boot (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_in   (word0),
    .boot_word (boot_word)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CTRL: rd_mux = {{(DATA_W-1){1'b0}}, en_q};
      SEL_CMD:  rd_mux = {busy, cmd_q};
      SEL_STAT: rd_mux = {{(DATA_W-1){1'b0}}, err_q};
      SEL_BOOT: rd_mux = boot_word;
      SEL_WIN:  rd_mux = win_word;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

endmodule

// File: rtl/fuse_ctrl_chk.sv
module fuse_ctrl_chk #(
  parameter int PROG_CYCLES = 16,
  parameter int NBITS       = 1024
) (
  input logic             clk,
  input logic             rst_n,
  input logic             por_n,
  input logic             en_q,
  input logic             busy,
  input logic             err,
  input logic             rd_en,
  input logic             rd_valid,
  input logic [NBITS-1:0] fuse_bits
);

  logic [31:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else busy_len <= '0;
  end

  // R5
  bits_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (($past(fuse_bits) & ~fuse_bits) == '0));

  // R5
  one_bit_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    ($countones($past(fuse_bits) ^ fuse_bits) <= 1));

  // R4
  busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && en_q) |-> (busy_len == PROG_CYCLES));

  // R7
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!busy && !err));

  // R8
  reject_no_blow_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(err) |-> $stable(fuse_bits));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err || !en_q));

  // R11
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R11
  rd_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

endmodule

bind fuse_ctrl fuse_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES), .NBITS(FUSE_BYTES * 8)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .por_n     (por_n),
  .en_q      (en_q),
  .busy      (busy),
  .err       (err_q),
  .rd_en     (rd_en),
  .rd_valid  (rd_valid),
  .fuse_bits (fuse_bits)
);

// File: tb/fuse_ctrl_test.sv
module fuse_ctrl_test;

  localparam int P = 16;
  localparam logic [7:0] A_CTRL = 8'h00, A_CMD = 8'h04, A_STAT = 8'h08, A_BOOT = 8'h0C,
                         A_WIN = 8'h80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  shadow [128];
  bit          finished = 0;

  always #10 clk = ~clk;

  fuse_ctrl uut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en), .rd_en(rd_en),
    .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [31:0] cmd(bit start, bit val, int b, int byt, int mac);
    return (32'(start) << 31) | (32'(mac) << 10) | (32'(byt) << 4) | (32'(b) << 1) | 32'(val);
  endfunction

  function automatic logic [31:0] win_exp(int w);
    return {shadow[4*w+3], shadow[4*w+2], shadow[4*w+1], shadow[4*w]};
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string t);
    rd_en = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // Launch, wait out the program time, update the model if the command is legal.
  task automatic prog(bit val, int b, int byt, int mac);
    wr(A_CMD, cmd(1, val, b, byt, mac));
    idle(P + 2);
    if (val && byt < 32 && mac < 4) shadow[byt*4 + mac][b] = 1'b1;
  endtask

  // Monitor: pops expected items as responses appear.
  always @(negedge clk) begin
    if (rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected response: actual %h expected none", rd_data);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) shadow[i] = 8'h00;
    idle(4);
    por_n = 1'b1; rst_n = 1'b1;
    idle(3);

    // R1 reset state
    rd(A_CTRL, 32'h0, "R1 ctrl");
    rd(A_CMD,  32'h0, "R1 cmd");
    rd(A_STAT, 32'h0, "R1 status");
    rd(A_BOOT, 32'h0, "R10 boot empty");

    wr(A_CTRL, 32'h1);
    rd(A_CTRL, 32'h1, "R1 ctrl enabled");

    // R3 / R4: launch and timing of the start flag
    wr(A_CMD, cmd(1, 1, 5, 3, 2));
    rd(A_CMD, cmd(1, 1, 5, 3, 2), "R3 start readback");
    idle(P - 2);
    rd(A_CMD, cmd(1, 1, 5, 3, 2), "R4 start last busy cycle");
    rd(A_CMD, cmd(0, 1, 5, 3, 2), "R4 start cleared");
    shadow[3*4 + 2][5] = 1'b1;
    rd(A_WIN + 8'd12, win_exp(3), "R4 bit visible");
    rd(A_WIN + 8'd12, 32'h0020_0000, "R2 lane 2 bit 5");

    // R2 interleave
    prog(1, 0, 0, 0);
    prog(1, 7, 31, 3);
    prog(1, 3, 0, 1);
    prog(1, 7, 0, 2);
    rd(A_WIN, 32'h0080_0801, "R2 word 0");
    rd(A_WIN + 8'd124, 32'h8000_0000, "R2 word 31");
    rd(A_WIN + 8'd125, 32'h8000_0000, "R11 low address bits ignored");

    // R5 data 0 blows nothing, set bits stay
    prog(0, 1, 5, 0);
    rd(A_WIN + 8'd20, 32'h0, "R5 value 0 no blow");
    prog(1, 0, 0, 0);
    rd(A_WIN, win_exp(0), "R5 reprogram keeps bit");

    // R6 command while busy ignored
    wr(A_CMD, cmd(1, 1, 2, 7, 1));
    wr(A_CMD, cmd(1, 1, 6, 7, 0));
    idle(P + 2);
    shadow[7*4 + 1][2] = 1'b1;
    rd(A_WIN + 8'd28, 32'h0000_0400, "R6 only first command blew");
    rd(A_CMD, cmd(0, 1, 2, 7, 1), "R6 command register kept");

    // R7 command while disabled ignored
    wr(A_CTRL, 32'h0);
    wr(A_CMD, cmd(1, 1, 0, 9, 0));
    rd(A_CMD, 32'h0, "R7 no launch when off");
    wr(A_CTRL, 32'h1);
    idle(P + 2);
    rd(A_WIN + 8'd36, 32'h0, "R7 nothing blown");

    // R8 out-of-range commands
    wr(A_CMD, cmd(1, 1, 1, 32, 0));
    idle(P + 2);
    rd(A_STAT, 32'h1, "R8 byte range error");
    rd(A_CMD, 32'h0, "R8 no launch");
    rd(A_WIN, win_exp(0), "R8 byte 32 blew nothing");
    wr(A_CMD, cmd(1, 1, 0, 2, 4));
    idle(P + 2);
    rd(A_WIN + 8'd8, 32'h0, "R8 macro 4 blew nothing");
    prog(1, 6, 4, 3);
    rd(A_STAT, 32'h1, "R8 error sticky");
    rd(A_WIN + 8'd16, win_exp(4), "R8 legal command still works");

    // R9 disable clears and aborts
    wr(A_CTRL, 32'h0);
    rd(A_STAT, 32'h0, "R9 error cleared");
    wr(A_CTRL, 32'h1);
    wr(A_CMD, cmd(1, 1, 4, 10, 3));
    idle(3);
    wr(A_CTRL, 32'h0);
    rd(A_CMD, 32'h0, "R9 command cleared");
    wr(A_CTRL, 32'h1);
    idle(P + 2);
    rd(A_WIN + 8'd40, 32'h0, "R9 aborted blow");
    rd(A_WIN + 8'd124, win_exp(31), "R9 contents kept");

    // R10 / R12 system reset recaptures boot word, keeps fuses
    rd(A_BOOT, 32'h0, "R10 boot stale until reset");
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    rd(A_CTRL, 32'h0, "R1 ctrl after system reset");
    rd(A_BOOT, 32'h0080_0801, "R10 boot captured");
    rd(A_WIN + 8'd124, win_exp(31), "R12 fuses survive system reset");
    wr(A_CTRL, 32'h1);
    prog(1, 4, 0, 0);
    rd(A_WIN, 32'h0080_0811, "R10 word 0 updated");
    rd(A_BOOT, 32'h0080_0801, "R10 boot unchanged");

    // R12 power-on reset clears fuses
    por_n = 1'b0;
    idle(2);
    por_n = 1'b1;
    idle(2);
    for (int i = 0; i < 128; i++) shadow[i] = 8'h00;
    rd(A_WIN, 32'h0, "R12 word 0 cleared");
    rd(A_WIN + 8'd124, 32'h0, "R12 word 31 cleared");

    idle(3);
    if (exp_q.size() != 0) begin
      fails++; checks++;
      $display("FAIL R11 missing responses: actual %0d pending expected 0", exp_q.size());
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule